// File: doc/BRIEF.md
# Prioritized Interrupt Mask Controller

This block decides which interrupt a small 8-bit CPU core takes next. It has three kinds of input:

- a set of internal maskable request lines, each with its own enable;
- an external active-low maskable request pin, which is maskable source 0;
- an active-low non-maskable request pin.

The block holds a global mask bit that gates every maskable source at once. It also holds a non-maskable mask bit, which software can only clear. A 4-bit field lets software promote one maskable source above all the others.

The CPU pulses a boundary strobe between instructions. On that strobe the block samples all pending requests. One cycle later it reports the winner as a one-cycle acknowledge pulse, together with the source index and the address of that source's 16-bit entry in the vector table. The CPU signals the return from a service routine with a one-cycle pulse, and the block then restores the mask bit it saved when the interrupt was taken.

The external pin starts out level sensitive. It can be switched to falling-edge capture, but only during a short window after reset.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The global mask bit is 1 after reset. While it is 1, no maskable source is acknowledged. It is cleared by a write with value 0.
- R2: The non-maskable mask bit is 1 after reset. A write of 0 clears it. A write of 1 has no effect, so it never returns to 1 before the next reset.
- R3: Any acknowledge sets the global mask bit and saves its previous value. A return pulse restores the saved value.
- R4: The external pin is low-level sensitive after reset. The mode write (1 = falling edge) takes effect only during the first WIN_CYC (64) cycles after reset. Later mode writes are ignored.
- R5: The 4-bit priority-select field resets to 0, which selects the external pin. An eligible source whose index equals the field wins over every other maskable source. A field value of NUM_SRC or more promotes nothing.
- R6: A maskable source i has vector address 16'hFFF2 - 2*i. The non-maskable request has vector address 16'hFFF4 and reports index 4'hF. Every address lies in the range FFC0 to FFFF.
- R7: A maskable source is eligible only when its request is active, its enable bit is 1 and the global mask bit is 0.
- R8: A falling edge on the non-maskable pin is latched as pending. The pending request is taken at a boundary once the non-maskable mask bit is 0. It wins over all maskable sources and ignores the global mask bit.
- R9: Among maskable sources that are not promoted, a lower index has higher priority. Requests are sampled only in a cycle with the boundary strobe high, and the acknowledge appears in the following cycle.
- R10: In edge mode, a falling edge on the external pin is latched. The latch is cleared when source 0 is acknowledged, so a pin that stays low does not request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | External maskable request pin, active low |
| nmi_n | input | 1 | Non-maskable request pin, falling-edge captured |
| src_req | input | NUM_SRC-1 | Internal maskable requests; bit i is source i (bits 1 to NUM_SRC-1) |
| src_en | input | NUM_SRC | Individual enable per maskable source |
| wr_imask_en | input | 1 | Write strobe for the global mask bit |
| wr_imask_val | input | 1 | Value written to the global mask bit |
| wr_nmask_en | input | 1 | Write strobe for the non-maskable mask bit |
| wr_nmask_val | input | 1 | Value written to the non-maskable mask bit (only 0 acts) |
| wr_edge_en | input | 1 | Write strobe for the external pin mode |
| wr_edge_val | input | 1 | Pin mode: 0 level, 1 falling edge |
| wr_prio_en | input | 1 | Write strobe for the priority-select field |
| wr_prio_val | input | 4 | Index of the promoted source |
| boundary | input | 1 | Instruction-boundary strobe from the CPU |
| rti | input | 1 | Return-from-interrupt pulse |
| ack | output | 1 | One-cycle acknowledge pulse |
| ack_nmi | output | 1 | The acknowledged source is the non-maskable request |
| ack_idx | output | 4 | Index of the acknowledged source |
| vec_addr | output | 16 | Vector table entry address of the acknowledged source |

## Verification
Arbitration is tried with several request patterns:

- A lone external-pin request confirms the vector arithmetic for index 0.
- Two internal requests (3 and 5) show the ascending fixed order. The same pair after promoting 5, and again with 5 disabled, separates promotion from enables.
- A non-maskable pulse alongside an internal request shows which of the two classes wins.

The mask bits are tested with requests held active across accept and return pulses. This distinguishes the automatic mask set from the restore of the saved value. Two further cases separate level capture from edge capture: a pin that stays low through two boundaries, once with the mode written inside the post-reset window and once with it written after the window.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SRC = 15,
  parameter int WIN_CYC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_n,
  input  logic               nmi_n,
  input  logic [NUM_SRC-1:1] src_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               wr_imask_en,
  input  logic               wr_imask_val,
  input  logic               wr_nmask_en,
  input  logic               wr_nmask_val,
  input  logic               wr_edge_en,
  input  logic               wr_edge_val,
  input  logic               wr_prio_en,
  input  logic [3:0]         wr_prio_val,
  input  logic               boundary,
  input  logic               rti,
  output logic               ack,
  output logic               ack_nmi,
  output logic [3:0]         ack_idx,
  output logic [15:0]        vec_addr
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [15:0] NMI_VEC = 16'hFFF4;
  localparam logic [15:0] MSK_TOP = 16'hFFF2;

  logic          imask_q, imask_sv, nmask_q, edge_mode, edge_lat;
  logic          irq_q, nmi_q, nmi_pend;
  logic [3:0]    prio_q;
  logic [CW-1:0] win_cnt;
  logic          win_done;

  logic [NUM_SRC-1:0] req, elig;
  logic [15:0]        elig16;
  logic               ext_req, any_m, take_nmi, take_m, take;
  logic [3:0]         win_idx;

  assign win_done = (win_cnt == CW'(WIN_CYC));
  assign ext_req  = edge_mode ? edge_lat : ~irq_n;
  assign req      = {src_req, ext_req};
  assign elig     = req & src_en & {NUM_SRC{~imask_q}};
  assign elig16   = 16'(elig);
  assign any_m    = |elig;
  assign take_nmi = boundary & nmi_pend & ~nmask_q;
  assign take_m   = boundary & any_m & ~take_nmi;
  assign take     = take_nmi | take_m;

  always_comb begin
    win_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (elig[i]) win_idx = 4'(i);
    if (int'(prio_q) < NUM_SRC && elig16[prio_q]) win_idx = prio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      irq_q   <= 1'b1;
      nmi_q   <= 1'b1;
    end else begin
      if (!win_done) win_cnt <= win_cnt + 1'b1;
      irq_q <= irq_n;
      nmi_q <= nmi_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q   <= 1'b1;
      imask_sv  <= 1'b1;
      nmask_q   <= 1'b1;
      edge_mode <= 1'b0;
      prio_q    <= 4'd0;
    end else begin
      if (take) begin
        imask_sv <= imask_q;
        imask_q  <= 1'b1;
      end else if (rti) begin
        imask_q <= imask_sv;
      end else if (wr_imask_en) begin
        imask_q <= wr_imask_val;
      end
      if (wr_nmask_en && !wr_nmask_val) nmask_q <= 1'b0;
      if (wr_edge_en && !win_done) edge_mode <= wr_edge_val;
      if (wr_prio_en) prio_q <= wr_prio_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_lat <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      if (!edge_mode) edge_lat <= 1'b0;
      else if (irq_q && !irq_n) edge_lat <= 1'b1;
      else if (take_m && win_idx == 4'd0) edge_lat <= 1'b0;
      if (nmi_q && !nmi_n) nmi_pend <= 1'b1;
      else if (take_nmi) nmi_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      ack_nmi  <= 1'b0;
      ack_idx  <= 4'd0;
      vec_addr <= 16'd0;
    end else begin
      ack <= take;
      if (take_nmi) begin
        ack_nmi  <= 1'b1;
        ack_idx  <= 4'hF;
        vec_addr <= NMI_VEC;
      end else if (take_m) begin
        ack_nmi  <= 1'b0;
        ack_idx  <= win_idx;
        vec_addr <= MSK_TOP - {11'd0, win_idx, 1'b0};
      end
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        imask,
  input logic        nmask,
  input logic        edge_mode,
  input logic        win_done,
  input logic        ack,
  input logic        ack_nmi,
  input logic [15:0] vec_addr
);
  AST_NMASK_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(nmask)); // R2
  AST_ACK_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> imask); // R3
  AST_MASKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_nmi) |-> !$past(imask)); // R1
  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_nmi) |-> vec_addr == 16'hFFF4); // R6
  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vec_addr >= 16'hFFC0 && !vec_addr[0])); // R6
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> $stable(edge_mode)); // R4
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .imask(imask_q), .nmask(nmask_q),
  .edge_mode(edge_mode), .win_done(win_done), .ack(ack),
  .ack_nmi(ack_nmi), .vec_addr(vec_addr)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 15;

  logic clk = 0, rst_n = 0, irq_n = 1, nmi_n = 1;
  logic [NS-1:1] src_req = '0;
  logic [NS-1:0] src_en = '1;
  logic wr_imask_en = 0, wr_imask_val = 0, wr_nmask_en = 0, wr_nmask_val = 0;
  logic wr_edge_en = 0, wr_edge_val = 0, wr_prio_en = 0;
  logic [3:0] wr_prio_val = 0;
  logic boundary = 0, rti = 0;
  logic ack, ack_nmi;
  logic [3:0] ack_idx;
  logic [15:0] vec_addr;
  int tests = 0, fails = 0, cyc = 0;

  irq_prio_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; irq_n = 1; nmi_n = 1; src_req = '0; src_en = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic strobe();
    @(negedge clk) boundary = 1;
    @(negedge clk) boundary = 0;
  endtask

  task automatic pulse_rti();
    @(negedge clk) rti = 1;
    @(negedge clk) rti = 0;
  endtask

  task automatic nmi_pulse();
    @(negedge clk) nmi_n = 0;
    @(negedge clk) nmi_n = 1;
  endtask

  task automatic wr_imask(input logic v);
    @(negedge clk) begin wr_imask_en = 1; wr_imask_val = v; end
    @(negedge clk) wr_imask_en = 0;
  endtask

  task automatic wr_nmask(input logic v);
    @(negedge clk) begin wr_nmask_en = 1; wr_nmask_val = v; end
    @(negedge clk) wr_nmask_en = 0;
  endtask

  task automatic wr_edge(input logic v);
    @(negedge clk) begin wr_edge_en = 1; wr_edge_val = v; end
    @(negedge clk) wr_edge_en = 0;
  endtask

  task automatic wr_prio(input logic [3:0] v);
    @(negedge clk) begin wr_prio_en = 1; wr_prio_val = v; end
    @(negedge clk) wr_prio_en = 0;
  endtask

  task automatic t_reset_mask();
    do_reset();
    @(negedge clk);
    chk("R1 reset ack", ack, 0);
    chk("R1 reset vec", vec_addr, 0);
    irq_n = 0; src_req = '1;
    strobe();
    chk("R1 masked after reset", ack, 0);
    @(negedge clk) begin irq_n = 1; src_req = '0; end
  endtask

  task automatic t_ext_level_and_restore();
    wr_imask(0);
    irq_n = 0;
    @(negedge clk);
    chk("R9 no boundary no ack", ack, 0);
    strobe();
    chk("R9 ack on boundary", ack, 1);
    chk("R5 default promotes pin idx", ack_idx, 0);
    chk("R6 pin vector", vec_addr, 16'hFFF2);
    strobe();
    chk("R3 mask set on accept", ack, 0);
    pulse_rti();
    strobe();
    chk("R3 rti restores clear mask", ack, 1);
    irq_n = 1;
    pulse_rti();
  endtask

  task automatic t_fixed_and_promote();
    src_req[3] = 1; src_req[5] = 1;
    wr_prio(4'd9);
    strobe();
    chk("R9 lowest index wins", ack_idx, 3);
    chk("R6 idx3 vector", vec_addr, 16'hFFEC);
    pulse_rti();
    wr_prio(4'd5);
    strobe();
    chk("R5 promoted idx5", ack_idx, 5);
    chk("R6 idx5 vector", vec_addr, 16'hFFE8);
    pulse_rti();
    src_en[5] = 0;
    strobe();
    chk("R7 disabled promoted skipped", ack_idx, 3);
    pulse_rti();
    src_en = '0;
    strobe();
    chk("R7 all disabled", ack, 0);
    src_en = '1; src_req = '0;
  endtask

  task automatic t_nmi();
    nmi_pulse();
    strobe();
    chk("R8 pending held while masked", ack, 0);
    wr_nmask(0);
    strobe();
    chk("R8 nmi taken", ack_nmi, 1);
    chk("R6 nmi idx", ack_idx, 4'hF);
    chk("R6 nmi vector", vec_addr, 16'hFFF4);
    wr_nmask(1);
    nmi_pulse();
    strobe();
    chk("R2 set write ignored", {ack, ack_nmi}, 2'b11);
    wr_imask(0);
    src_req[2] = 1;
    nmi_pulse();
    strobe();
    chk("R8 nmi outranks maskable", {ack_nmi, ack_idx}, {1'b1, 4'hF});
    wr_imask(0);
    strobe();
    chk("R9 maskable after nmi", {ack_nmi, ack_idx}, {1'b0, 4'd2});
    src_req = '0;
  endtask

  task automatic t_late_mode_write();
    do_reset();
    repeat (70) @(negedge clk);
    wr_edge(1);
    wr_imask(0);
    irq_n = 0;
    strobe();
    chk("R4 first take", ack, 1);
    pulse_rti();
    strobe();
    chk("R4 late write ignored, level", ack, 1);
    irq_n = 1;
  endtask

  task automatic t_edge_mode();
    do_reset();
    wr_edge(1);
    wr_imask(0);
    @(negedge clk) irq_n = 0;
    strobe();
    chk("R10 edge latched", {ack, ack_idx}, {1'b1, 4'd0});
    pulse_rti();
    strobe();
    chk("R10 latch cleared on ack", ack, 0);
    @(negedge clk) irq_n = 1;
    @(negedge clk) irq_n = 0;
    strobe();
    chk("R4 new edge taken", ack, 1);
    irq_n = 1;
  endtask

  initial begin
    t_reset_mask();
    t_ext_level_and_restore();
    t_fixed_and_promote();
    t_nmi();
    t_late_mode_write();
    t_edge_mode();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule